// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block keeps a running calendar and clock: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-second strobe from an external prescaler moves the count forward by one second, carrying through minutes, hours, days, months and years. Month lengths and leap years are handled. Software-visible copies of every field are presented in either packed BCD or plain binary, and the hour can be shown in 24-hour form or in 12-hour form with a PM flag.

The running count and the visible copies are kept apart. Each accepted strobe opens an update window of a fixed number of clock cycles. During this window an in-progress flag is raised. When the window closes, the visible copies are refreshed from the count and a one-cycle done strobe is issued, which downstream alarm and update-ended logic can sample. A hold input freezes the visible copies so that software can write a consistent time. Releasing the hold makes the count take the written time. A load port writes any single field in the encoding currently selected.

Top module: `cal_time_counter`

## Requirements
- R1: After reset the visible fields read seconds 0x00, minutes 0x00, hours 0x00, day of week 0x01, day of month 0x01, month 0x01 and year 0x00. `uip_o` and `done_o` are low.
- R2: A `tick_i` pulse advances the count by one second and opens an update window only while `osc_ctl_i` equals 3'b010. With any other value the pulse is ignored: no window opens, nothing is refreshed and the visible fields keep their values.
- R3: Seconds and minutes wrap from 59 to 0 and carry into the next field. Hours wrap from 23 to 0 and carry into both day fields. Day of week counts 1 to 7 and returns to 1 after 7.
- R4: February has 29 days when the full year CENTURY*100 + yy is divisible by 4 and is either not divisible by 100 or divisible by 400. Otherwise it has 28 days. April, June, September and November have 30 days, and every other month has 31.
- R5: When the day of month passes the month length, it returns to 1 and the month advances. After month 12 the month returns to 1 and the year advances, wrapping from 99 to 0.
- R6: With `fmt_bin_i` low, fields are presented and loads are interpreted as packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0. With `fmt_bin_i` high, they are plain binary.
- R7: With `fmt_24h_i` low, the hour field shows the hour mod 12, with bit 7 set for hours 12 to 23. A loaded hour with bit 7 set has 12 added. In 24-hour mode bit 7 of a loaded hour is dropped.
- R8: An accepted tick raises `uip_o` (while `hold_i` is low) for UIP_CYCLES clock cycles. When the window ends, the visible fields are refreshed and `done_o` pulses for exactly one cycle. A tick inside an open window restarts it.
- R9: While `hold_i` is high, and in the cycle after it falls, the visible fields are not refreshed and `uip_o` stays low. Loads under hold change only the visible field. When the hold falls, the count takes the decoded values of all visible fields.
- R10: A load (`ld_en_i`) writes `ld_data_i` into the visible field chosen by `ld_sel_i` on the next clock. The codes are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, and 7 for no field. With `hold_i` low the same field of the count also takes the decoded value, and the other fields keep running.
- R11: When a load and an accepted tick fall in the same cycle, the advance is applied on top of the loaded value. When a load falls on the cycle in which a window ends, the loaded value wins over the refresh for that field.
- R12: Loaded values are not range-checked. A field loaded beyond its limit wraps to its lowest value and carries on its next increment (for example, seconds loaded as 75 become 0 with a minute carry).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second strobe, one clock wide |
| osc_ctl_i | input | 3 | Oscillator control; counting runs only at 3'b010 |
| fmt_bin_i | input | 1 | 1 = binary fields, 0 = packed BCD |
| fmt_24h_i | input | 1 | 1 = 24-hour hours, 0 = 12-hour with PM bit 7 |
| hold_i | input | 1 | Freezes visible fields; count reloads on release |
| ld_en_i | input | 1 | Field load strobe |
| ld_sel_i | input | 3 | Field selected for load |
| ld_data_i | input | 8 | Encoded value to load |
| sec_o | output | 8 | Visible seconds |
| min_o | output | 8 | Visible minutes |
| hour_o | output | 8 | Visible hours |
| wday_o | output | 8 | Visible day of week |
| mday_o | output | 8 | Visible day of month |
| mon_o | output | 8 | Visible month |
| year_o | output | 8 | Visible two-digit year |
| uip_o | output | 1 | Update in progress |
| done_o | output | 1 | One-cycle pulse when an update window closes |

## Verification
Two functions can collide in one cycle. The first is a field load against the refresh that closes an update window. The second is a field load against an accepted tick. Both are provoked on purpose: a load is driven together with a tick, and another load is timed to land exactly UIP_CYCLES cycles after a tick, on the cycle the window closes. A long random phase then scatters ticks, loads, hold toggles and mode changes so that further coincidences occur. A behavioural model in the bench applies the stated priorities: the advance goes on top of the loaded value, and the load wins over the refresh. Every output is compared against this model on every clock, with literal expected values checked after the directed collisions.

// File: rtl/cal_pkg.sv
package cal_pkg;

   localparam int DW = 8;
   localparam int NF = 7;

   localparam int IX_SEC  = 0;
   localparam int IX_MIN  = 1;
   localparam int IX_HOUR = 2;
   localparam int IX_WDAY = 3;
   localparam int IX_MDAY = 4;
   localparam int IX_MON  = 5;
   localparam int IX_YEAR = 6;

   localparam logic [2:0] OSC_RUN = 3'b010;

   typedef logic [DW-1:0] fld_t;
   typedef logic [NF-1:0][DW-1:0] tod_t;

   // year, month, mday, wday, hour, min, sec
   localparam tod_t TOD_RESET = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

   function automatic fld_t to_bcd(fld_t v);
      fld_t tens;
      fld_t ones;
      tens = v / 8'd10;
      ones = v % 8'd10;
      return {tens[3:0], ones[3:0]};
   endfunction

   function automatic fld_t from_bcd(fld_t b);
      fld_t hi;
      fld_t lo;
      hi = {4'h0, b[7:4]};
      lo = {4'h0, b[3:0]};
      return hi * 8'd10 + lo;
   endfunction

   // Two-digit year inside the century given by the parameter.
   function automatic logic leap_year(fld_t yy, int century);
      logic res;
      if (yy[1:0] != 2'b00)  res = 1'b0;
      else if (yy != 8'd0)   res = 1'b1;
      else                   res = ((century % 4) == 0);
      return res;
   endfunction

   function automatic fld_t month_days(fld_t mon, logic leap);
      fld_t d;
      case (mon)
         8'd2:                        d = leap ? 8'd29 : 8'd28;
         8'd4, 8'd6, 8'd9, 8'd11:     d = 8'd30;
         default:                     d = 8'd31;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/cal_field_codec.sv
module cal_field_codec
   import cal_pkg::*;
#(
   parameter bit IS_HOUR = 1'b0
) (
   input  logic bin_mode_i,
   input  logic h24_i,
   input  fld_t cnt_i,
   input  fld_t raw_i,
   output fld_t enc_o,
   output fld_t dec_o
);

   generate
      if (IS_HOUR) begin : g_hour
         fld_t h12;
         fld_t shown;
         fld_t body;
         fld_t low7;
         fld_t base;
         always_comb begin
            h12   = cnt_i % 8'd12;
            shown = h24_i ? cnt_i : h12;
            body  = bin_mode_i ? shown : to_bcd(shown);
            enc_o = (!h24_i && (cnt_i >= 8'd12)) ? (body | 8'h80) : body;
            low7  = {1'b0, raw_i[6:0]};
            base  = bin_mode_i ? low7 : from_bcd(low7);
            dec_o = (!h24_i && raw_i[7]) ? (base + 8'd12) : base;
         end
      end else begin : g_plain
         logic unused_h24;
         assign unused_h24 = h24_i;
         assign enc_o = bin_mode_i ? cnt_i : to_bcd(cnt_i);
         assign dec_o = bin_mode_i ? raw_i : from_bcd(raw_i);
      end
   endgenerate

endmodule

// File: rtl/cal_advance.sv
module cal_advance
   import cal_pkg::*;
#(
   parameter int CENTURY = 20
) (
   input  tod_t cur_i,
   output tod_t nxt_o
);

   generate
      if (CENTURY < 0 || CENTURY > 99) begin : g_bad_century
         $error("cal_advance: CENTURY must lie in 0..99");
      end
   endgenerate

   fld_t s1, m1, h1, w1, d1, mo1, y1, dim;
   logic c_min, c_hour, c_day, c_mon, c_year;

   always_comb begin
      nxt_o  = cur_i;
      s1     = cur_i[IX_SEC]  + 8'd1;
      m1     = cur_i[IX_MIN]  + 8'd1;
      h1     = cur_i[IX_HOUR] + 8'd1;
      w1     = cur_i[IX_WDAY] + 8'd1;
      d1     = cur_i[IX_MDAY] + 8'd1;
      mo1    = cur_i[IX_MON]  + 8'd1;
      y1     = cur_i[IX_YEAR] + 8'd1;
      dim    = month_days(cur_i[IX_MON], leap_year(cur_i[IX_YEAR], CENTURY));
      c_min  = (s1 >= 8'd60);
      c_hour = c_min  && (m1 >= 8'd60);
      c_day  = c_hour && (h1 >= 8'd24);
      c_mon  = c_day  && (d1 != 8'd0) && (d1 > dim);
      c_year = c_mon  && (mo1 > 8'd12);

      nxt_o[IX_SEC] = c_min ? 8'd0 : s1;
      if (c_min)  nxt_o[IX_MIN]  = c_hour ? 8'd0 : m1;
      if (c_hour) nxt_o[IX_HOUR] = c_day  ? 8'd0 : h1;
      if (c_day) begin
         nxt_o[IX_WDAY] = (w1 > 8'd7) ? 8'd1 : w1;
         nxt_o[IX_MDAY] = ((d1 == 8'd0) || c_mon) ? 8'd1 : d1;
      end
      if (c_mon)  nxt_o[IX_MON]  = c_year ? 8'd1 : mo1;
      if (c_year) nxt_o[IX_YEAR] = (y1 >= 8'd100) ? 8'd0 : y1;
   end

endmodule

// File: rtl/cal_update_window.sv
module cal_update_window #(
   parameter int UIP_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic end_o
);

   localparam int CW = (UIP_CYCLES > 1) ? $clog2(UIP_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(UIP_CYCLES - 1);

   generate
      if (UIP_CYCLES < 1) begin : g_bad_len
         $error("cal_update_window: UIP_CYCLES must be at least 1");
      end
   endgenerate

   logic          busy_q;
   logic [CW-1:0] cnt_q;

   assign end_o  = busy_q && (cnt_q == '0) && !start_i;
   assign busy_o = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         cnt_q  <= LAST;
      end else if (end_o) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         cnt_q  <= cnt_q - 1'b1;
      end
   end

   // R8: the window opens only from an accepted tick
   a_r8_opens_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(start_i));

   // R8: a window closes for one cycle only
   a_r8_single_end: assert property (@(posedge clk) disable iff (!rst_n)
      end_o |=> !end_o);

endmodule

// File: rtl/cal_time_counter.sv
module cal_time_counter
   import cal_pkg::*;
#(
   parameter int CENTURY    = 20,
   parameter int UIP_CYCLES = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic [2:0] osc_ctl_i,
   input  logic       fmt_bin_i,
   input  logic       fmt_24h_i,
   input  logic       hold_i,
   input  logic       ld_en_i,
   input  logic [2:0] ld_sel_i,
   input  logic [7:0] ld_data_i,
   output logic [7:0] sec_o,
   output logic [7:0] min_o,
   output logic [7:0] hour_o,
   output logic [7:0] wday_o,
   output logic [7:0] mday_o,
   output logic [7:0] mon_o,
   output logic [7:0] year_o,
   output logic       uip_o,
   output logic       done_o
);

   tod_t cnt_q, vis_q;
   tod_t cnt_base, cnt_adv, vis_d, raw_sel, enc_val, dec_val;
   logic [NF-1:0] ld_hit;
   logic hold_q, done_q;
   logic run, win_busy, win_end, release_now, refresh;

   assign run         = tick_i && (osc_ctl_i == OSC_RUN);
   assign release_now = hold_q && !hold_i;
   assign refresh     = win_end && !hold_i && !hold_q;

   cal_update_window #(.UIP_CYCLES(UIP_CYCLES)) u_window (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (run),
      .busy_o  (win_busy),
      .end_o   (win_end)
   );

   generate
      for (genvar f = 0; f < NF; f++) begin : g_fld
         assign ld_hit[f]  = ld_en_i && (ld_sel_i == 3'(f));
         assign raw_sel[f] = ld_hit[f] ? ld_data_i : vis_q[f];

         cal_field_codec #(.IS_HOUR(f == IX_HOUR)) u_codec (
            .bin_mode_i (fmt_bin_i),
            .h24_i      (fmt_24h_i),
            .cnt_i      (cnt_q[f]),
            .raw_i      (raw_sel[f]),
            .enc_o      (enc_val[f]),
            .dec_o      (dec_val[f])
         );

         assign cnt_base[f] = (release_now || (ld_hit[f] && !hold_i)) ? dec_val[f] : cnt_q[f];
         assign vis_d[f]    = ld_hit[f] ? ld_data_i :
                              refresh   ? enc_val[f] : vis_q[f];
      end
   endgenerate

   cal_advance #(.CENTURY(CENTURY)) u_advance (
      .cur_i (cnt_base),
      .nxt_o (cnt_adv)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= TOD_RESET;
         vis_q  <= TOD_RESET;
         hold_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         cnt_q  <= run ? cnt_adv : cnt_base;
         vis_q  <= vis_d;
         hold_q <= hold_i;
         done_q <= win_end;
      end
   end

   assign sec_o  = vis_q[IX_SEC];
   assign min_o  = vis_q[IX_MIN];
   assign hour_o = vis_q[IX_HOUR];
   assign wday_o = vis_q[IX_WDAY];
   assign mday_o = vis_q[IX_MDAY];
   assign mon_o  = vis_q[IX_MON];
   assign year_o = vis_q[IX_YEAR];
   assign uip_o  = win_busy && !hold_i;
   assign done_o = done_q;

   // R2: no window without an accepted tick
   a_r2_idle_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_busy && !(tick_i && osc_ctl_i == OSC_RUN)) |=> !win_busy);

   // R8: done is a single-cycle pulse
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8: done follows a closed window
   a_r8_done_after_window: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !win_busy || $past(tick_i));

   // R9: held visible fields do not move without a load
   a_r9_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_i && !ld_en_i) |=> $stable(vis_q));

   // R10: a seconds load appears on the next clock
   a_r10_load_seconds: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en_i && ld_sel_i == 3'd0) |=> (sec_o == $past(ld_data_i)));

endmodule

// File: tb/test_cal_time_counter.sv
module test_cal_time_counter;

   localparam int U    = 8;
   localparam int CENT = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [2:0] osc = 3'b010;
   logic       fmt_bin = 1'b0;
   logic       h24 = 1'b1;
   logic       hold = 1'b0;
   logic       ld_en = 1'b0;
   logic [2:0] ld_sel = 3'd7;
   logic [7:0] ld_data = 8'h00;
   logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o;
   logic       uip_o, done_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit started = 0;
   string cur_req = "R1";
   string fname [7] = '{"sec", "min", "hour", "wday", "mday", "mon", "year"};

   always #4 clk = ~clk;

   cal_time_counter #(.CENTURY(CENT), .UIP_CYCLES(U)) i_cal_time_counter (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .osc_ctl_i(osc),
      .fmt_bin_i(fmt_bin), .fmt_24h_i(h24), .hold_i(hold),
      .ld_en_i(ld_en), .ld_sel_i(ld_sel), .ld_data_i(ld_data),
      .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
      .mday_o(mday_o), .mon_o(mon_o), .year_o(year_o),
      .uip_o(uip_o), .done_o(done_o)
   );

   // ---------------- behavioural reference ----------------
   int mc [7];
   int mv [7];
   int nb [7];
   int nv [7];
   int mbusy, mcnt, mdone, mhprev;
   int run, wend, rel, refr, hit, raw, dv, dm;

   function automatic int bcdp(int x);
      return (((x / 10) & 15) << 4) | (x % 10);
   endfunction

   function automatic int bcdu(int b);
      return ((b >> 4) & 15) * 10 + (b & 15);
   endfunction

   function automatic int enc_f(int f, int val, bit bin, bit h24m);
      int x, h, b;
      x = val & 255;
      if (f == 2 && !h24m) begin
         h = x % 12;
         b = bin ? h : bcdp(h);
         return b | ((x >= 12) ? 128 : 0);
      end
      return bin ? x : (bcdp(x) & 255);
   endfunction

   function automatic int dec_f(int f, int r, bit bin, bit h24m);
      int b;
      if (f == 2) begin
         b = bin ? (r & 127) : bcdu(r & 127);
         if (!h24m && (r & 128) != 0) b = b + 12;
         return b & 255;
      end
      return bin ? r : bcdu(r);
   endfunction

   function automatic int days_in(int mon, int yy);
      int full;
      bit leap;
      full = CENT * 100 + yy;
      leap = (full % 4 == 0) && ((full % 100 != 0) || (full % 400 == 0));
      if (mon == 2) return leap ? 29 : 28;
      if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
      return 31;
   endfunction

   task automatic adv_model;
      nb[0] = (nb[0] + 1) & 255;
      if (nb[0] >= 60) begin
         nb[0] = 0;
         nb[1] = (nb[1] + 1) & 255;
         if (nb[1] >= 60) begin
            nb[1] = 0;
            nb[2] = (nb[2] + 1) & 255;
            if (nb[2] >= 24) begin
               nb[2] = 0;
               nb[3] = (nb[3] + 1) & 255;
               if (nb[3] > 7) nb[3] = 1;
               dm = days_in(nb[5], nb[6]);
               nb[4] = (nb[4] + 1) & 255;
               if (nb[4] == 0) nb[4] = 1;
               else if (nb[4] > dm) begin
                  nb[4] = 1;
                  nb[5] = (nb[5] + 1) & 255;
                  if (nb[5] > 12) begin
                     nb[5] = 1;
                     nb[6] = (nb[6] + 1) & 255;
                     if (nb[6] >= 100) nb[6] = 0;
                  end
               end
            end
         end
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mc = '{0, 0, 0, 1, 1, 1, 0};
         mv = '{0, 0, 0, 1, 1, 1, 0};
         mbusy = 0; mcnt = 0; mdone = 0; mhprev = 0;
      end else begin
         run  = (tick && osc == 3'b010) ? 1 : 0;
         wend = (mbusy != 0 && mcnt == 0 && run == 0) ? 1 : 0;
         rel  = (mhprev != 0 && !hold) ? 1 : 0;
         refr = (wend != 0 && !hold && mhprev == 0) ? 1 : 0;
         for (int f = 0; f < 7; f++) begin
            hit = (ld_en && int'(ld_sel) == f) ? 1 : 0;
            raw = (hit != 0) ? int'(ld_data) : mv[f];
            dv  = dec_f(f, raw, fmt_bin, h24);
            nb[f] = (rel != 0 || (hit != 0 && !hold)) ? dv : mc[f];
            nv[f] = (hit != 0) ? int'(ld_data) :
                    (refr != 0) ? enc_f(f, mc[f], fmt_bin, h24) : mv[f];
         end
         if (run != 0) adv_model();
         for (int f = 0; f < 7; f++) begin
            mc[f] = nb[f];
            mv[f] = nv[f];
         end
         if (run != 0) begin
            mbusy = 1; mcnt = U - 1;
         end else if (wend != 0) begin
            mbusy = 0;
         end else if (mbusy != 0) begin
            mcnt = mcnt - 1;
         end
         mdone  = wend;
         mhprev = hold ? 1 : 0;
      end
   end

   // ---------------- checking ----------------
   task automatic chk(string req, string name, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, name, act, exp);
      end
   endtask

   function automatic int out_of(int f);
      case (f)
         0: return int'(sec_o);
         1: return int'(min_o);
         2: return int'(hour_o);
         3: return int'(wday_o);
         4: return int'(mday_o);
         5: return int'(mon_o);
         default: return int'(year_o);
      endcase
   endfunction

   always @(negedge clk) begin
      if (rst_n && started) begin
         for (int f = 0; f < 7; f++) chk(cur_req, fname[f], out_of(f), mv[f]);
         chk(cur_req, "uip", int'(uip_o), (mbusy != 0 && !hold) ? 1 : 0);
         chk(cur_req, "done", int'(done_o), mdone);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++;
         errors++;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   task automatic step(int n);
      repeat (n) begin
         @(posedge clk);
         #2;
         tick  = 1'b0;
         ld_en = 1'b0;
      end
   endtask

   task automatic pulse_tick;
      tick = 1'b1;
      step(1);
      step(U + 3);
   endtask

   task automatic load(int sel, int data);
      ld_en   = 1'b1;
      ld_sel  = 3'(sel);
      ld_data = 8'(data);
      step(1);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      started = 1;
      step(2);
      // R1 reset values
      chk("R1", "sec", int'(sec_o), 0);
      chk("R1", "wday", int'(wday_o), 1);
      chk("R1", "mon", int'(mon_o), 1);
      chk("R1", "uip", int'(uip_o), 0);

      // R2 oscillator gate
      cur_req = "R2";
      osc = 3'b000;
      pulse_tick();
      chk("R2", "sec", int'(sec_o), 0);
      osc = 3'b010;
      pulse_tick();
      chk("R2", "sec", int'(sec_o), 1);

      // R10 loads with hold low
      cur_req = "R10";
      load(0, 'h58); load(1, 'h59); load(2, 'h23); load(3, 'h07);
      load(4, 'h31); load(5, 'h12); load(6, 'h99);
      chk("R10", "hour", int'(hour_o), 'h23);

      // R3 / R5 full rollover
      cur_req = "R3";
      pulse_tick();
      chk("R3", "sec", int'(sec_o), 'h59);
      cur_req = "R5";
      pulse_tick();
      chk("R5", "min", int'(min_o), 0);
      chk("R3", "wday", int'(wday_o), 1);
      chk("R5", "mday", int'(mday_o), 1);
      chk("R5", "mon", int'(mon_o), 1);
      chk("R5", "year", int'(year_o), 0);

      // R4 leap rules
      cur_req = "R4";
      load(5, 'h02); load(4, 'h28); load(6, 'h24);
      load(2, 'h23); load(1, 'h59); load(0, 'h59);
      pulse_tick();
      chk("R4", "mday", int'(mday_o), 'h29);
      load(6, 'h23); load(4, 'h28); load(2, 'h23); load(1, 'h59); load(0, 'h59);
      pulse_tick();
      chk("R4", "mon", int'(mon_o), 'h03);
      load(5, 'h02); load(6, 'h00); load(4, 'h28);
      load(2, 'h23); load(1, 'h59); load(0, 'h59);
      pulse_tick();
      chk("R4", "mday", int'(mday_o), 'h29);
      load(5, 'h04); load(4, 'h30); load(2, 'h23); load(1, 'h59); load(0, 'h59);
      pulse_tick();
      chk("R4", "mon", int'(mon_o), 'h05);

      // R6 binary presentation
      cur_req = "R6";
      fmt_bin = 1'b1;
      load(4, 25);
      pulse_tick();
      chk("R6", "mday", int'(mday_o), 25);

      // R7 12-hour form
      cur_req = "R7";
      h24 = 1'b0;
      load(2, 13);
      pulse_tick();
      chk("R7", "hour", int'(hour_o), 'h81);
      fmt_bin = 1'b0;
      load(2, 'h85);
      pulse_tick();
      chk("R7", "hour", int'(hour_o), 'h85);
      h24 = 1'b1;
      pulse_tick();
      chk("R7", "hour", int'(hour_o), 'h17);

      // R8 tick inside an open window
      cur_req = "R8";
      tick = 1'b1; step(1); step(3);
      tick = 1'b1; step(1); step(U + 3);

      // R9 hold and release
      cur_req = "R9";
      hold = 1'b1;
      pulse_tick();
      load(0, 'h30); load(1, 'h10);
      step(2);
      hold = 1'b0;
      step(2);
      pulse_tick();
      chk("R9", "sec", int'(sec_o), 'h31);
      chk("R9", "min", int'(min_o), 'h10);

      // R11 coincidences
      cur_req = "R11";
      tick = 1'b1; ld_en = 1'b1; ld_sel = 3'd0; ld_data = 8'h40;
      step(1); step(U + 3);
      chk("R11", "sec", int'(sec_o), 'h41);
      tick = 1'b1; step(1); step(U - 1);
      ld_en = 1'b1; ld_sel = 3'd1; ld_data = 8'h33;
      step(1); step(4);
      chk("R11", "min", int'(min_o), 'h33);

      // R12 out-of-range load
      cur_req = "R12";
      fmt_bin = 1'b1;
      load(0, 75); load(1, 10);
      pulse_tick();
      chk("R12", "sec", int'(sec_o), 0);
      chk("R12", "min", int'(min_o), 11);

      // random mix, judged by the model
      cur_req = "R11";
      for (int i = 0; i < 4000; i++) begin
         if ($urandom % 40 == 0) hold = ~hold;
         if ($urandom % 60 == 0) fmt_bin = ~fmt_bin;
         if ($urandom % 60 == 0) h24 = ~h24;
         if ($urandom % 30 == 0) osc = ($urandom % 4 == 0) ? 3'($urandom) : 3'b010;
         if ($urandom % 6 == 0) tick = 1'b1;
         if ($urandom % 8 == 0) begin
            ld_en  = 1'b1;
            ld_sel = 3'($urandom % 8);
            if (ld_sel == 3'd6) ld_data = 8'(enc_f(6, int'($urandom % 100), fmt_bin, h24));
            else ld_data = 8'($urandom);
         end
         step(1);
      end
      hold = 1'b0;
      step(U + 4);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule